// File: doc/BRIEF.md
# Variable-Length Serial Shift Register

This block is a bidirectional shift buffer built on one 24-bit register. A parallel word is loaded for transmission and leaves serially, most significant bit first, on `ser_out`. At the same time, serial bits arriving on `ser_in` are collected. When a word ends, they are presented as a parallel word on `rx_data`. Every transfer uses the register in both directions at once.

A run-time mode input sets the transfer length to 8, 16 or 24 bits. The active section of the register always occupies the top bytes. Short words therefore sit MSB-aligned inside the register, while the parallel ports carry them right-justified. Bits below the active section stay zero. A bit counter raises a one-cycle `word_done` pulse after the last shift of each word and then starts over. The surrounding controller issues the shift strobes and performs the parallel loads, and it reacts to `word_done`. The register itself has no direct read or write path.

Top module: `msb_window_shifter`

## Requirements
- R1: After reset `ser_out`, `word_done` and `rx_data` are all zero.
- R2: `ser_out` always shows the top bit (bit 23) of the register, so right after a load it shows the most significant bit of the loaded word for the selected length.
- R3: Each cycle with `shift_en` high moves the register one place toward bit 23, so transmit bits leave MSB first, one per strobe.
- R4: With `mode` = 2'b00 the word is 8 bits and only bits 23:16 shift. `word_done` follows the 8th shift, and `rx_data` then holds the received byte in bits 7:0 with bits 23:8 zero.
- R5: With `mode` = 2'b01 the word is 16 bits and bits 23:8 shift. `word_done` follows the 16th shift, and `rx_data` holds the received word in bits 15:0 with bits 23:16 zero.
- R6: With `mode` = 2'b10 the word is 24 bits and all bits shift. `word_done` follows the 24th shift, and `rx_data` holds all 24 received bits.
- R7: `word_done` is high for exactly one cycle, in the cycle after the final shift strobe, and the bit count then restarts from zero.
- R8: In 8- and 16-bit modes, load bits above the word length are ignored: only the low 8 or 16 bits of `load_data` appear on `ser_out`.
- R9: A load in the same cycle as the final shift of a word still completes that word (pulse and capture of the shifted data), and it also starts the new word with its first bit on `ser_out`.
- R10: With `shift_en` and `load` both low, `ser_out` and `rx_data` hold and `word_done` stays low.
- R11: `mode` = 2'b11 behaves as the 24-bit mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Word length: 00 = 8, 01 = 16, 10/11 = 24 bits |
| load | input | 1 | Load `load_data` into the register and restart the bit count |
| load_data | input | 24 | Transmit word, right-justified |
| shift_en | input | 1 | Shift strobe, one bit per high cycle |
| ser_in | input | 1 | Serial receive bit, sampled with `shift_en` |
| ser_out | output | 1 | Serial transmit bit (register bit 23) |
| word_done | output | 1 | One-cycle pulse after the last shift of a word |
| rx_data | output | 24 | Last received word, right-justified |

## Verification
A wrong shift window or insertion point corrupts the `ser_out` bit sequence within one strobe of the fault. It also puts nonzero upper bits or a displaced byte into `rx_data` at the next `word_done`. A bit counter that is off by one moves `word_done` one strobe early or late. A counter that fails to restart delays or drops the pulse of the next word, which the back-to-back scenario exposes. Register state that leaks below the window shows up only when later shifts pull it into bit 23, so every word is shifted fully out and compared bit by bit.

// File: rtl/msb_window_shifter.sv
module msb_window_shifter #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   mode,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic         ser_out,
  output logic         word_done,
  output logic [W-1:0] rx_data
);
  localparam int CW  = $clog2(W + 1);
  localparam int SEG = W / 3;

  logic [W-1:0]  sr, shifted, win_mask;
  logic [CW-1:0] len, gap, cnt;
  logic          last;

  always_comb begin
    case (mode)
      2'b00:   len = CW'(SEG);
      2'b01:   len = CW'(2 * SEG);
      default: len = CW'(W);
    endcase
  end

  assign gap      = CW'(W) - len;
  assign win_mask = {W{1'b1}} << gap;
  assign shifted  = ({sr[W-2:0], 1'b0} | (W'(ser_in) << gap)) & win_mask;
  assign last     = shift_en && ((cnt + 1'b1) >= len);
  assign ser_out  = sr[W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr        <= '0;
      cnt       <= '0;
      word_done <= 1'b0;
      rx_data   <= '0;
    end else begin
      word_done <= last;
      if (last) rx_data <= shifted >> gap;
      if (load) begin
        sr  <= load_data << gap;
        cnt <= '0;
      end else if (shift_en) begin
        sr  <= shifted;
        cnt <= last ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/msb_window_shifter_chk.sv
module msb_window_shifter_chk #(
  parameter int W = 24
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   mode,
  input logic         load,
  input logic [W-1:0] load_data,
  input logic         shift_en,
  input logic         ser_out,
  input logic         word_done,
  input logic [W-1:0] rx_data
);
  // R7
  word_done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> !word_done);

  // R7
  done_after_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |-> $past(shift_en));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> ($stable(ser_out) && $stable(rx_data) && !word_done));

  // R2
  load_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && mode[1]) |=> (ser_out == $past(load_data[W-1])));

  // R4
  rx8_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && $past(mode) == 2'b00) |-> (rx_data[W-1:W/3] == '0));
endmodule

bind msb_window_shifter msb_window_shifter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .load(load), .load_data(load_data),
  .shift_en(shift_en), .ser_out(ser_out), .word_done(word_done), .rx_data(rx_data)
);

// File: tb/sim_msb_window_shifter.sv
`timescale 1ns/1ps
module sim_msb_window_shifter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic        load = 1'b0;
  logic [23:0] load_data = '0;
  logic        shift_en = 1'b0;
  logic        ser_in = 1'b0;
  logic        ser_out, word_done;
  logic [23:0] rx_data;
  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  msb_window_shifter u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .load(load), .load_data(load_data),
    .shift_en(shift_en), .ser_in(ser_in), .ser_out(ser_out),
    .word_done(word_done), .rx_data(rx_data)
  );

  function automatic int len_of(input logic [1:0] m);
    return (m == 2'b00) ? 8 : (m == 2'b01) ? 16 : 24;
  endfunction

  task automatic check(input logic ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    check(ser_out == 1'b0,   "R1 ser_out",   24'(ser_out),   24'h0);
    check(word_done == 1'b0, "R1 word_done", 24'(word_done), 24'h0);
    check(rx_data == 24'h0,  "R1 rx_data",   rx_data,        24'h0);
  endtask

  task automatic t_word(input logic [1:0] m, input logic [23:0] tx, input logic [23:0] rx, input string req);
    int n = len_of(m);
    int bad_out = 0;
    int bad_done = 0;
    mode = m; load = 1'b1; load_data = tx;
    @(negedge clk);
    load = 1'b0;
    // R2, R8: first bit out is bit n-1 of tx
    check(ser_out == tx[n-1], "R2/R8 first bit", 24'(ser_out), 24'(tx[n-1]));
    for (int i = n - 1; i >= 0; i--) begin
      // R3, R8: MSB-first transmit of the low n bits only
      if (ser_out != tx[i]) bad_out++;
      shift_en = 1'b1; ser_in = rx[i];
      @(negedge clk);
      if (i > 0 && word_done) bad_done++;
    end
    shift_en = 1'b0;
    check(bad_out == 0, {req, " R3 serial out"}, 24'(bad_out), 24'h0);
    check(bad_done == 0, {req, " early word_done"}, 24'(bad_done), 24'h0);
    check(word_done == 1'b1, {req, " word_done"}, 24'(word_done), 24'h1);
    check(rx_data == (rx & ((24'h1 << n) - 1'b1)) || n == 24 && rx_data == rx,
          {req, " rx_data"}, rx_data, (n == 24) ? rx : (rx & ((24'h1 << n) - 1'b1)));
    @(negedge clk);
    // R7 single pulse
    check(word_done == 1'b0, "R7 pulse ends", 24'(word_done), 24'h0);
  endtask

  task automatic t_idle;
    logic held;
    logic [23:0] rx_before;
    mode = 2'b10; load = 1'b1; load_data = 24'h800001;
    @(negedge clk);
    load = 1'b0;
    held = ser_out;
    rx_before = rx_data;
    repeat (5) @(negedge clk);
    // R10
    check(ser_out == held && held == 1'b1, "R10 ser_out hold", 24'(ser_out), 24'h1);
    check(word_done == 1'b0, "R10 no word_done", 24'(word_done), 24'h0);
    check(rx_data == rx_before, "R10 rx_data hold", rx_data, rx_before);
  endtask

  task automatic t_back_to_back;
    logic [7:0] a_rx = 8'h71;
    logic [7:0] b_tx = 8'h3C;
    logic [7:0] b_rx = 8'hE7;
    int bad = 0;
    int early = 0;
    mode = 2'b00; load = 1'b1; load_data = 24'h000096;
    @(negedge clk);
    load = 1'b0;
    for (int i = 7; i >= 1; i--) begin
      shift_en = 1'b1; ser_in = a_rx[i];
      @(negedge clk);
    end
    shift_en = 1'b1; ser_in = a_rx[0]; load = 1'b1; load_data = {16'hFFFF, b_tx};
    @(negedge clk);
    shift_en = 1'b0; load = 1'b0;
    // R9: old word completes, new word starts
    check(word_done == 1'b1, "R9 word_done", 24'(word_done), 24'h1);
    check(rx_data == 24'h000071, "R9 rx_data", rx_data, 24'h000071);
    check(ser_out == b_tx[7], "R9 new first bit", 24'(ser_out), 24'(b_tx[7]));
    for (int i = 7; i >= 0; i--) begin
      if (ser_out != b_tx[i]) bad++;
      shift_en = 1'b1; ser_in = b_rx[i];
      @(negedge clk);
      if (i > 0 && word_done) early++;
    end
    shift_en = 1'b0;
    check(bad == 0, "R9 new word serial out", 24'(bad), 24'h0);
    // R7: counter restarted, so the pulse comes after 8 more shifts
    check(early == 0, "R7 restart no early pulse", 24'(early), 24'h0);
    check(word_done == 1'b1, "R7 restart word_done", 24'(word_done), 24'h1);
    check(rx_data == 24'h0000E7, "R4 second byte", rx_data, 24'h0000E7);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 24'h1, 24'h0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_word(2'b00, 24'hABCD5A, 24'h0000C3, "R4 8-bit");
    t_word(2'b01, 24'hFF1234, 24'h00BEEF, "R5 16-bit");
    t_word(2'b10, 24'hA5F00F, 24'h3C69E1, "R6 24-bit");
    t_word(2'b11, 24'h5A0FF1, 24'h0F0F0F, "R11 mode 11");
    t_word(2'b00, 24'hFFFF01, 24'h000080, "R8 8-bit ignore upper");
    t_idle();
    t_back_to_back();
    finish_run();
  end
endmodule